// File: doc/BRIEF.md
# Error Interrupt Status Aggregator

This block gathers six single-cycle error event pulses from a link controller into sticky status bits. Each bit stays set until software writes a 1 to it. Software sees the status in two ways: the raw view shows every captured event whether or not its source is enabled, and the masked view shows only the enabled ones. The per-source enable is changed through a pair of registers. One adds enables (write 1 to enable) and the other removes them (write 1 to disable), so no read-modify-write is needed.

Two outputs are driven from the masked status. The error interrupt is raised when any enabled source has a captured event. The fatal indicator is raised only for the two sources treated as fatal. The source bits are:
- bit 0: system summary error
- bit 1: fatal error
- bit 2: non-fatal error
- bit 3: correctable error
- bit 4: fatal tag lookup failure on the on-chip bus
- bit 5: end-to-end CRC error

Bits 1 and 4 form the fatal class.

Top module: `err_agg_top`

## Requirements
- R1: After reset, the raw status and the enables are zero, all four registers read zero, and both `err_irq_o` and `err_fatal_o` are low.
- R2: A pulse on `err_evt_i[i]` sets raw status bit i at the next clock edge. The bit is set whatever the enable, and it stays set until it is cleared.
- R3: Reading the masked status (byte offset 0x4) returns the raw status AND the enables.
- R4: A write to offset 0x8 sets each enable bit written as 1. A write to offset 0xC clears each enable bit written as 1. Bits written as 0 keep their enable. Reading either offset returns the enables.
- R5: A write to the raw status (offset 0x0) or to the masked status (offset 0x4) clears every raw status bit written as 1 and leaves bits written as 0 unchanged.
- R6: When an event on bit i arrives in the same cycle as a write that clears bit i, the bit stays set.
- R7: `err_irq_o` is high exactly when some bit is set in both the raw status and the enables.
- R8: `err_fatal_o` is high exactly when bit 1 or bit 4 is set in both the raw status and the enables. The other bits never raise it.
- R9: Bits 31 to 6 of every register read as zero, and writes to them have no effect. Byte-offset bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | 6 | Single-cycle error event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset (0x0 raw, 0x4 masked, 0x8 enable-set, 0xC enable-clear) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| err_irq_o | output | 1 | Error interrupt |
| err_fatal_o | output | 1 | Fatal error indicator |

## Verification
The assertions assume that a write strobe addresses only one register per cycle. Under that assumption an enable bit is never set and cleared in the same cycle, and a status clear and an enable change never coincide. The assertions also assume that event inputs are clean, synchronous pulses. The bench keeps within these limits: it drives inputs at the falling edge, issues one write per cycle, and raises events only as single-cycle pulses. It deliberately lines up an event with a clear of the same bit to reach the collision case.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;

    typedef enum logic [1:0] {
        SEL_RAW    = 2'd0,
        SEL_MASKED = 2'd1,
        SEL_EN_SET = 2'd2,
        SEL_EN_CLR = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/err_agg_status.sv
module err_agg_status #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
    } st_t;

    st_t st_d, st_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_comb begin
            // event has priority over a clear of the same bit (R6)
            st_d.raw[i] = evt_i[i] | (st_q.raw[i] & ~clr_i[i]);
        end

        // R2: a set bit without a clear stays set
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.raw[i] && !clr_i[i]) |=> st_q.raw[i]);
        // R6: an event always lands, even under a clear
        a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> st_q.raw[i]);
        // R5: a clear without an event empties the bit
        a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !st_q.raw[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;

endmodule

// File: rtl/err_agg_enable.sv
module err_agg_enable #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] en_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } en_st_t;

    en_st_t en_d, en_q;

    always_comb begin
        en_d    = en_q;
        en_d.en = (en_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R4: set and clear strobes take effect next cycle
        a_r4_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] && !clr_i[i]) |=> en_q.en[i]);
        a_r4_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] |=> !en_q.en[i]);
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !clr_i[i]) |=> $stable(en_q.en[i]));
    end

    assign en_o = en_q.en;

endmodule

// File: rtl/err_agg_regif.sv
module err_agg_regif
    import err_agg_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_SRC-1:0] st_clr_o,
    output logic [NUM_SRC-1:0] en_set_o,
    output logic [NUM_SRC-1:0] en_clr_o,
    output logic [DATA_W-1:0]  reg_rdata_o
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] rd_bits;
    logic               unused_bits;

    assign sel         = reg_sel_e'(reg_addr_i[3:2]);
    assign wbits       = reg_wdata_i[NUM_SRC-1:0];
    assign unused_bits = ^{reg_wdata_i[DATA_W-1:NUM_SRC], reg_addr_i[1:0]};

    always_comb begin
        st_clr_o = '0;
        en_set_o = '0;
        en_clr_o = '0;
        if (reg_wr_i) begin
            unique case (sel)
                SEL_RAW, SEL_MASKED: st_clr_o = wbits;
                SEL_EN_SET:          en_set_o = wbits;
                SEL_EN_CLR:          en_clr_o = wbits;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RAW:    rd_bits = raw_i;
            SEL_MASKED: rd_bits = raw_i & en_i;
            default:    rd_bits = en_i;
        endcase
        reg_rdata_o = {{PAD_W{1'b0}}, rd_bits};
    end

endmodule

// File: rtl/err_agg_top.sv
module err_agg_top #(
    parameter int          NUM_SRC    = 6,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 4,
    parameter logic [5:0]  FATAL_MASK = 6'b01_0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               err_irq_o,
    output logic               err_fatal_o
);

    logic [NUM_SRC-1:0] raw, en, masked;
    logic [NUM_SRC-1:0] st_clr, en_set, en_clr;

    err_agg_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regif_i (
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .raw_i       (raw),
        .en_i        (en),
        .st_clr_o    (st_clr),
        .en_set_o    (en_set),
        .en_clr_o    (en_clr),
        .reg_rdata_o (reg_rdata_o)
    );

    err_agg_status #(.NUM_SRC(NUM_SRC)) status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (err_evt_i),
        .clr_i (st_clr),
        .raw_o (raw)
    );

    err_agg_enable #(.NUM_SRC(NUM_SRC)) enable_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en)
    );

    assign masked      = raw & en;
    assign err_irq_o   = |masked;
    assign err_fatal_o = |(masked & FATAL_MASK[NUM_SRC-1:0]);

    // R8: the fatal class is a subset of the interrupt sources
    a_r8_fatal_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_fatal_o |-> err_irq_o);
    // R7: no interrupt without at least one enable
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> (en != '0));
    // R7: an enabled event raises the interrupt next cycle
    a_r7_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_evt_i & en & ~en_clr) != '0) |=> err_irq_o);

endmodule

// File: tb/err_agg_top_tb_top.sv
module err_agg_top_tb_top;

    localparam logic [3:0] A_RAW = 4'h0, A_MSK = 4'h4, A_SET = 4'h8, A_CLR = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  err_evt_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        err_irq_o, err_fatal_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [5:0] exp_raw = '0;
    logic [5:0] exp_en  = '0;

    always #5 clk = ~clk;

    err_agg_top dut_i (
        .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .err_irq_o(err_irq_o), .err_fatal_o(err_fatal_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    // compare every register view and both outputs against the model
    task automatic check_all(input string req);
        logic [31:0] d;
        logic [5:0]  m;
        m = exp_raw & exp_en;
        rd(A_RAW, d); check({req, " raw"},    d, {26'd0, exp_raw});
        rd(A_MSK, d); check({req, " masked"}, d, {26'd0, m});
        rd(A_SET, d); check({req, " en@set"}, d, {26'd0, exp_en});
        rd(A_CLR, d); check({req, " en@clr"}, d, {26'd0, exp_en});
        check({req, " irq"},   {31'd0, err_irq_o},   {31'd0, |m});
        check({req, " fatal"}, {31'd0, err_fatal_o}, {31'd0, m[1] | m[4]});
    endtask

    // one-cycle operation: optional write and optional event together
    task automatic cycle(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                         input logic [5:0] evt);
        @(negedge clk);
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd; err_evt_i = evt;
        @(negedge clk);
        reg_wr_i = 1'b0; err_evt_i = '0; reg_wdata_i = '0;
        if (wr && (a[3:2] == 2'd0 || a[3:2] == 2'd1)) exp_raw = exp_raw & ~wd[5:0];
        if (wr && a[3:2] == 2'd2) exp_en = exp_en | wd[5:0];
        if (wr && a[3:2] == 2'd3) exp_en = exp_en & ~wd[5:0];
        exp_raw = exp_raw | evt;
    endtask

    task automatic t_reset;
        check_all("R1");
    endtask

    task automatic t_capture;
        cycle(1'b0, A_RAW, 0, 6'h08);
        check_all("R2 single");
        cycle(1'b0, A_RAW, 0, 6'h21);
        check_all("R2 sticky");
        cycle(1'b0, A_RAW, 0, 6'h00);
        check_all("R2 hold");
    endtask

    task automatic t_enable;
        cycle(1'b1, A_SET, 32'h08, 0);
        check_all("R4 set R3 R7");
        cycle(1'b1, A_SET, 32'hFFFF_FFC0, 0);
        check_all("R9 upper set ignored");
        cycle(1'b1, A_CLR, 32'h08, 0);
        check_all("R4 clr R7");
        cycle(1'b1, A_SET, 32'h3F, 0);
        check_all("R4 all R8 non-fatal");
    endtask

    task automatic t_fatal;
        cycle(1'b0, A_RAW, 0, 6'h10);
        check_all("R8 bit4");
        cycle(1'b1, A_MSK, 32'h10, 0);
        check_all("R5 masked w1c");
        cycle(1'b0, A_RAW, 0, 6'h02);
        check_all("R8 bit1");
        cycle(1'b1, A_CLR, 32'h02, 0);
        check_all("R8 disabled fatal");
        cycle(1'b1, A_SET, 32'h02, 0);
    endtask

    task automatic t_w1c;
        cycle(1'b1, A_RAW, 32'h0, 0);
        check_all("R5 zero write");
        cycle(1'b1, A_RAW + 4'h3, 32'h09, 0);
        check_all("R5 R9 partial clear");
    endtask

    task automatic t_collide;
        cycle(1'b1, A_RAW, 32'h20, 6'h20);
        check_all("R6 same bit");
        cycle(1'b1, A_RAW, 32'h22, 6'h01);
        check_all("R6 other bit");
        cycle(1'b1, A_RAW, 32'hFFFF_FFFF, 0);
        check_all("R5 R9 clear all");
        cycle(1'b1, A_CLR, 32'hFFFF_FFFF, 0);
        check_all("R4 clear all");
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_enable();
        t_fatal();
        t_w1c();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule